// File: doc/BRIEF.md
# Instruction Breakpoint Match Controller

This block watches the fetch and retire events of a simple in-order core and raises debug break requests when an instruction address matches one of its channels. Each channel holds an enable, a compare address, a don't-care mask and a timing choice. The timing choice decides whether the break is taken before the matched instruction runs or after it has completed.

For a break taken before execution, the channel reacts at fetch and reports the matched instruction's own address as the resume PC. For a break taken after execution, it reacts at retire and reports the address of the next instruction to run. A delayed branch first lets its delay slot retire, then reports the branch target or the address two instructions past the branch. Retire events that are flagged as cancelled belong to instructions that never executed, such as ones skipped by a taken branch or ones behind a faulting instruction. These events set no flag.

Match flags are sticky and are cleared by writing zero to them. A break request is a one-cycle pulse that carries the PC to save. After a break the block ignores further fetch matches, and starts no new break, until the core acknowledges entry into the handler.

Top module: `ibrk_ctrl`

## Requirements
- R1: With a channel enabled in before-execution mode, a valid fetch whose address matches sets that channel's flag and pulses `brk_req` one cycle later, with `brk_pc` equal to the fetch address.
- R2: A match compares only the address bits whose `cfg_mask` bit is 0; a bit set to 1 in the mask is ignored. A channel whose enable is 0 never matches.
- R3: With a channel in after-execution mode, a retire that is not cancelled and that matches (not a delayed branch) sets the flag and pulses `brk_req` one cycle later, with `brk_pc` = retire PC + 2.
- R4: An after-execution match on a delayed branch sets the flag one cycle after the branch retires but raises no break then. The break pulses one cycle after the next retire (the delay slot), with `brk_pc` = `ret_target` if `ret_taken` was 1, else branch PC + 4. If that delay-slot retire is cancelled, no break is raised.
- R5: A retire with `ret_cancel` = 1 sets no flag and raises no break.
- R6: From the cycle after a break pulse until the cycle after `brk_ack` is seen, fetch matches set no flag and no break is raised.
- R7: A before-execution match on a fetch with `fetch_fault` = 1 still sets the flag but raises no break.
- R8: Flags are sticky. A write with `flag_we` = 1 clears each flag whose `flag_wdata` bit is 0 and keeps each whose bit is 1. A match in the same cycle wins over the clear.
- R9: `brk_req` is never high in two consecutive cycles. When a fetch match and a retire match both fire in one cycle, the retire match supplies `brk_pc`.
- R10: After synchronous reset, all flags are 0, `brk_req` is 0 and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write channel configuration |
| cfg_ch | input | CHW | Channel index for configuration write |
| cfg_en | input | 1 | Channel enable |
| cfg_post | input | 1 | 0: break before execution, 1: break after execution |
| cfg_addr | input | AW | Compare address |
| cfg_mask | input | AW | Mask, 1 = bit ignored |
| flag_we | input | 1 | Write to the flag register |
| flag_wdata | input | NCH | Flag write data, 0 clears the bit |
| fetch_valid | input | 1 | Fetch event valid |
| fetch_pc | input | AW | Fetch address |
| fetch_fault | input | 1 | Fetch reported a translation fault |
| ret_valid | input | 1 | Retire event valid |
| ret_pc | input | AW | Retiring instruction address |
| ret_cancel | input | 1 | Retiring instruction did not execute |
| ret_dbranch | input | 1 | Retiring instruction is a delayed branch |
| ret_taken | input | 1 | Delayed branch is taken |
| ret_target | input | AW | Delayed branch target |
| brk_ack | input | 1 | Core has entered the break handler |
| flags | output | NCH | Sticky per-channel match flags |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | AW | PC to save for the handler |

## Verification
Every result of this block is due exactly one clock edge after the event that causes it. A flag is due after the fetch or retire that matched, and a break pulse with its PC is due after the fetch or the final retire. For a delayed branch the pulse is due one edge after the delay slot retires, and the edge after the branch itself must show the flag set with no pulse. The bench drives each event on a falling edge and checks all outputs at the next falling edge, before the next event is driven. Suppression after a break is checked on the cycle right after the pulse, and again on the first cycle after the acknowledge.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

  typedef enum logic {
    BRK_BEFORE = 1'b0,
    BRK_AFTER  = 1'b1
  } brk_mode_e;

  localparam int unsigned INSN_BYTES = 2;

endpackage

// File: rtl/ibrk_chan.sv
module ibrk_chan #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          wr_en,
  input  logic          wr_post,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_mask,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] ret_pc,
  output logic          hit_before,
  output logic          hit_after
);
  import ibrk_pkg::*;

  logic            en_q;
  brk_mode_e       mode_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= BRK_BEFORE;
      addr_q <= '0;
      mask_q <= '0;
    end else if (wr) begin
      en_q   <= wr_en;
      mode_q <= brk_mode_e'(wr_post);
      addr_q <= wr_addr;
      mask_q <= wr_mask;
    end
  end

  logic eq_fetch, eq_ret;
  always_comb begin
    eq_fetch   = ((fetch_pc ^ addr_q) & ~mask_q) == '0;
    eq_ret     = ((ret_pc   ^ addr_q) & ~mask_q) == '0;
    hit_before = en_q && (mode_q == BRK_BEFORE) && eq_fetch;
    hit_after  = en_q && (mode_q == BRK_AFTER)  && eq_ret;
  end

endmodule

// File: rtl/ibrk_after_seq.sv
module ibrk_after_seq #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ret_valid,
  input  logic          ret_cancel,
  input  logic          ret_dbranch,
  input  logic          ret_taken,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] ret_target,
  input  logic          any_hit,
  input  logic          block,
  output logic          fire,
  output logic [AW-1:0] fire_pc
);
  import ibrk_pkg::*;

  localparam logic [AW-1:0] STEP1 = AW'(INSN_BYTES);
  localparam logic [AW-1:0] STEP2 = AW'(2 * INSN_BYTES);

  logic          pend_q;
  logic [AW-1:0] pend_pc_q;

  always_comb begin
    fire    = 1'b0;
    fire_pc = ret_pc + STEP1;
    if (ret_valid && !block) begin
      if (pend_q) begin
        fire    = !ret_cancel;
        fire_pc = pend_pc_q;
      end else if (any_hit && !ret_dbranch) begin
        fire    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_pc_q <= '0;
    end else if (ret_valid) begin
      if (pend_q || block) begin
        pend_q <= 1'b0;
      end else if (any_hit && ret_dbranch) begin
        pend_q    <= 1'b1;
        pend_pc_q <= ret_taken ? ret_target : ret_pc + STEP2;
      end
    end
  end

endmodule

// File: rtl/ibrk_ctrl.sv
module ibrk_ctrl #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 32,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_en,
  input  logic           cfg_post,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [AW-1:0]  cfg_mask,
  input  logic           flag_we,
  input  logic [NCH-1:0] flag_wdata,
  input  logic           fetch_valid,
  input  logic [AW-1:0]  fetch_pc,
  input  logic           fetch_fault,
  input  logic           ret_valid,
  input  logic [AW-1:0]  ret_pc,
  input  logic           ret_cancel,
  input  logic           ret_dbranch,
  input  logic           ret_taken,
  input  logic [AW-1:0]  ret_target,
  input  logic           brk_ack,
  output logic [NCH-1:0] flags,
  output logic           brk_req,
  output logic [AW-1:0]  brk_pc
);

  logic [NCH-1:0] m_before, m_after;
  logic           hold_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ibrk_chan #(.AW(AW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr         (cfg_we && (cfg_ch == CHW'(i))),
      .wr_en      (cfg_en),
      .wr_post    (cfg_post),
      .wr_addr    (cfg_addr),
      .wr_mask    (cfg_mask),
      .fetch_pc   (fetch_pc),
      .ret_pc     (ret_pc),
      .hit_before (m_before[i]),
      .hit_after  (m_after[i])
    );
  end

  logic [NCH-1:0] set_before, set_after, keep;
  logic           before_fire, after_fire;
  logic [AW-1:0]  after_pc;

  always_comb begin
    set_before  = m_before & {NCH{fetch_valid && !hold_q}};
    set_after   = m_after  & {NCH{ret_valid && !ret_cancel}};
    before_fire = (|set_before) && !fetch_fault;
    keep        = flag_we ? flag_wdata : '1;
  end

  ibrk_after_seq #(.AW(AW)) u_after (
    .clk         (clk),
    .rst         (rst),
    .ret_valid   (ret_valid),
    .ret_cancel  (ret_cancel),
    .ret_dbranch (ret_dbranch),
    .ret_taken   (ret_taken),
    .ret_pc      (ret_pc),
    .ret_target  (ret_target),
    .any_hit     (|set_after),
    .block       (hold_q),
    .fire        (after_fire),
    .fire_pc     (after_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      brk_req <= 1'b0;
      brk_pc  <= '0;
      hold_q  <= 1'b0;
    end else begin
      flags   <= (flags & keep) | set_before | set_after;
      brk_req <= after_fire || before_fire;
      if (after_fire)       brk_pc <= after_pc;
      else if (before_fire) brk_pc <= fetch_pc;
      if (after_fire || before_fire) hold_q <= 1'b1;
      else if (brk_ack)              hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ibrk_ctrl_chk.sv
module ibrk_ctrl_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           fetch_valid,
  input logic           ret_valid,
  input logic           flag_we,
  input logic [NCH-1:0] flags,
  input logic           brk_req
);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);

  assert_cause_R1: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(fetch_valid || ret_valid));

  assert_rise_R8: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags)) != '0) |-> $past(fetch_valid || ret_valid));

  assert_fall_R8: assert property (@(posedge clk) disable iff (rst)
    ((~flags & $past(flags)) != '0) |-> $past(flag_we));

  assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == '0 && !brk_req));

endmodule

bind ibrk_ctrl ibrk_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .ret_valid   (ret_valid),
  .flag_we     (flag_we),
  .flags       (flags),
  .brk_req     (brk_req)
);

// File: tb/ibrk_ctrl_bench.sv
module ibrk_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic        cfg_en = 1'b0, cfg_post = 1'b0;
  logic [31:0] cfg_addr = '0, cfg_mask = '0;
  logic        flag_we = 1'b0;
  logic [1:0]  flag_wdata = '0;
  logic        fetch_valid = 1'b0, fetch_fault = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        ret_valid = 1'b0, ret_cancel = 1'b0, ret_dbranch = 1'b0, ret_taken = 1'b0;
  logic [31:0] ret_pc = '0, ret_target = '0;
  logic        brk_ack = 1'b0;
  logic [1:0]  flags;
  logic        brk_req;
  logic [31:0] brk_pc;

  always #2 clk = ~clk;

  ibrk_ctrl u_ibrk_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en),
    .cfg_post(cfg_post), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .fetch_fault(fetch_fault), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_cancel(ret_cancel), .ret_dbranch(ret_dbranch),
    .ret_taken(ret_taken), .ret_target(ret_target), .brk_ack(brk_ack),
    .flags(flags), .brk_req(brk_req), .brk_pc(brk_pc)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, logic ereq, logic [31:0] epc, logic [1:0] eflg);
    n_chk++;
    if (brk_req !== ereq || flags !== eflg || (ereq && brk_pc !== epc)) begin
      n_bad++;
      $display("FAIL %s: req=%0b pc=%h flags=%b expected req=%0b pc=%h flags=%b",
               req, brk_req, brk_pc, flags, ereq, epc, eflg);
    end
  endtask

  // Drive one cycle of events at a falling edge; return at the next falling edge.
  task automatic step(logic fv, logic [31:0] fpc, logic ff,
                      logic rv, logic [31:0] rpc, logic rc, logic rdb, logic rtk,
                      logic [31:0] rtgt, logic ack, logic fwe, logic [1:0] fwd);
    fetch_valid = fv; fetch_pc = fpc; fetch_fault = ff;
    ret_valid = rv; ret_pc = rpc; ret_cancel = rc; ret_dbranch = rdb;
    ret_taken = rtk; ret_target = rtgt; brk_ack = ack;
    flag_we = fwe; flag_wdata = fwd;
    @(negedge clk);
  endtask

  task automatic cfg(logic ch, logic en, logic post, logic [31:0] a, logic [31:0] m);
    cfg_we = 1'b1; cfg_ch = ch; cfg_en = en; cfg_post = post; cfg_addr = a; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  typedef struct packed {
    logic        fv;
    logic [31:0] fpc;
    logic        rv;
    logic [31:0] rpc;
    logic        rc;
    logic        ack;
    logic        clr;
    logic        ereq;
    logic [31:0] epc;
    logic [1:0]  eflg;
  } vec_t;

  // ch0: before-execution at 0x1000, ch1: after-execution at 0x2000
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    2'b00},
    '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 2'b01},
    '{1'b1, 32'h1002, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 32'h0,    2'b01},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    2'b00},
    '{1'b0, 32'h0,    1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h2002, 2'b10},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 32'h0,    2'b10},
    '{1'b0, 32'h0,    1'b1, 32'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,    2'b00},
    '{1'b1, 32'h1000, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h2002, 2'b11},
    '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 32'h0,    2'b00},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 32'h0,    2'b00},
    '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 2'b01},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b1, 1'b0, 32'h0,    2'b00}
  };
  localparam string VTAG [NV] = '{"R10 idle", "R1 fetch hit", "R6 held", "R8 clear",
    "R3 retire hit", "R6 ack", "R5 cancelled", "R9 both fire", "R6 fetch ignored",
    "R6 ack", "R1 after ack", "R8 clear"};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset", 1'b0, 32'h0, 2'b00);
    step(1, 32'h0, 0, 1, 32'h0, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R10 channels disabled", 1'b0, 32'h0, 2'b00);
    cfg(1'b0, 1'b1, 1'b0, 32'h1000, 32'h0);
    cfg(1'b1, 1'b1, 1'b1, 32'h2000, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].fv, VEC[k].fpc, 0, VEC[k].rv, VEC[k].rpc, VEC[k].rc, 0, 0, 32'h0,
           VEC[k].ack, VEC[k].clr, 2'b00);
      check(VTAG[k], VEC[k].ereq, VEC[k].epc, VEC[k].eflg);
    end

    // R4 delayed branch, taken
    step(0, 32'h0, 0, 1, 32'h2000, 0, 1, 1, 32'h3000, 0, 0, 2'b00);
    check("R4 taken branch no break", 1'b0, 32'h0, 2'b10);
    step(0, 32'h0, 0, 1, 32'h2002, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R4 taken slot break", 1'b1, 32'h3000, 2'b10);
    step(0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 1, 1, 2'b00);
    // R4 delayed branch, not taken
    step(0, 32'h0, 0, 1, 32'h2000, 0, 1, 0, 32'h3000, 0, 0, 2'b00);
    check("R4 untaken branch no break", 1'b0, 32'h0, 2'b10);
    step(0, 32'h0, 0, 1, 32'h2002, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R4 untaken slot break", 1'b1, 32'h2004, 2'b10);
    step(0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 1, 1, 2'b00);
    // R4 delay slot cancelled
    step(0, 32'h0, 0, 1, 32'h2000, 0, 1, 1, 32'h3000, 0, 0, 2'b00);
    step(0, 32'h0, 0, 1, 32'h2002, 1, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R4 cancelled slot", 1'b0, 32'h0, 2'b10);
    step(0, 32'h0, 0, 1, 32'h2100, 0, 0, 0, 32'h0, 0, 1, 2'b00);
    check("R4 pending dropped", 1'b0, 32'h0, 2'b00);
    // R7 fault on matched fetch
    step(1, 32'h1000, 1, 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R7 fault", 1'b0, 32'h0, 2'b01);
    // R8 clear with a 1 keeps the flag; same-cycle set wins
    step(0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, 2'b01);
    check("R8 write one keeps", 1'b0, 32'h0, 2'b01);
    step(1, 32'h1000, 1, 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, 2'b00);
    check("R8 set wins over clear", 1'b0, 32'h0, 2'b01);
    step(0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, 2'b00);
    // R2 mask and enable
    cfg(1'b0, 1'b1, 1'b0, 32'h1000, 32'h0000000F);
    step(1, 32'h100E, 0, 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R2 masked hit", 1'b1, 32'h100E, 2'b01);
    step(0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 1, 1, 2'b00);
    step(1, 32'h1010, 0, 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R2 unmasked miss", 1'b0, 32'h0, 2'b00);
    cfg(1'b0, 1'b0, 1'b0, 32'h1000, 32'h0);
    step(1, 32'h1000, 0, 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, 2'b00);
    check("R2 disabled", 1'b0, 32'h0, 2'b00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule